// File: doc/BRIEF.md
# Multi-width Shift and Rotate Unit

This block is the shift, rotate and complement datapath of a small CPU with condition codes. It is purely combinational. It takes an operand together with a size select for 8, 16 or 32 bits, an operation code, a flag that picks a move of one or two positions, and the incoming carry flag. In the same cycle it returns the result at the selected width and the new negative, zero, overflow and carry flags.

The CPU decoder drives the amount select straight from the opcode bit that picks one or two positions. The flag outputs go to the condition-code register, and the result goes to the register write-back path. The operation set covers logical and arithmetic shifts in both directions, plain rotates, rotates through carry, and bitwise complement.

Top module: `shift_rotate_unit`

## Requirements
- R1: `size_i` selects the working width: 0 is 8 bits, 1 is 16 bits, and 2 or 3 is 32 bits. Operand bits above the working width have no effect, and result bits above it are always 0.
- R2: `two_i` = 0 moves the operand by one position and `two_i` = 1 moves it by two. A two-position move equals two one-position moves in a row.
- R3: Logical left shift (`op_i` = 0) and arithmetic left shift (`op_i` = 2) fill the low end with zeros. C is the last bit shifted out of the top, so a two-position shift gives the bit just below the original MSB. Logical left shift clears V.
- R4: Logical right shift (`op_i` = 1) fills the top with zeros, gives C the last bit shifted out of the bottom, and clears V.
- R5: Arithmetic right shift (`op_i` = 3) copies the original sign bit into every vacated top position, gives C the last bit shifted out, and clears V.
- R6: Arithmetic left shift sets V when any bit shifted out, or the new sign bit, differs from the original sign bit. Otherwise V is 0.
- R7: Rotate left (`op_i` = 4) and rotate right (`op_i` = 5) feed each bit that leaves one end back into the other end. C receives the last bit moved around, and V is 0.
- R8: Rotate left through carry (`op_i` = 6) and rotate right through carry (`op_i` = 7) feed `carry_i` into the vacated end and put the bit shifted out into C. With a two-position move, the intermediate carry is passed on to the second step. V is 0.
- R9: After every operation, N equals the MSB of the result at the working width, and Z is 1 exactly when the result is zero at that width.
- R10: Complement (`op_i` = 8) inverts every bit of the operand at the working width and forces V and C to 0. `two_i` has no effect.
- R11: Every operation other than the two rotates through carry gives the same result and flags whatever the value of `carry_i`.
- R12: The unused operation codes 9 to 15 pass the operand through at the working width with V and C at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Operand, right-aligned |
| size_i | input | 2 | Working width select |
| op_i | input | 4 | Operation code |
| two_i | input | 1 | 0: one position, 1: two positions |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 32 | Result, zero above the working width |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag |
| c_o | output | 1 | Carry flag |

## Verification
The hardest case to bring about is a two-position rotate through carry in which the intermediate carry differs from both `carry_i` and the final carry. Only then does passing the carry between the two steps become visible. The stimulus reaches it with operands whose top two bits, or bottom two bits, differ, tried under both carry values. It then repeats the same move as two separate one-position operations, feeding back the returned carry, and compares the results. The overflow rule of the two-position arithmetic left shift is also exercised directly, with operands where only the bit third from the top disagrees with the sign.

// File: rtl/shru_pkg.sv
package shru_pkg;

  typedef enum logic [3:0] {
    OP_SHLL  = 4'd0,
    OP_SHLR  = 4'd1,
    OP_SHAL  = 4'd2,
    OP_SHAR  = 4'd3,
    OP_ROTL  = 4'd4,
    OP_ROTR  = 4'd5,
    OP_ROTXL = 4'd6,
    OP_ROTXR = 4'd7,
    OP_NOT   = 4'd8
  } shru_op_e;

  localparam int OP_W = 4;

endpackage

// File: rtl/shru_lane.sv
// One width lane: applies the selected operation to an LW-bit operand.
module shru_lane
  import shru_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic [LW-1:0] x_i,
  input  shru_op_e      op_i,
  input  logic          two_i,
  input  logic          cin_i,
  output logic [LW-1:0] r_o,
  output logic          c_o,
  output logic          v_o
);

  // Single-position step: returns {v, c, r}.
  function automatic logic [LW+1:0] step(input shru_op_e op,
                                         input logic [LW-1:0] x,
                                         input logic cin);
    logic [LW-1:0] r;
    logic c;
    logic v;
    v = 1'b0;
    case (op)
      OP_SHLL: begin r = {x[LW-2:0], 1'b0};   c = x[LW-1]; end
      OP_SHAL: begin r = {x[LW-2:0], 1'b0};   c = x[LW-1];
                     v = x[LW-1] ^ x[LW-2]; end
      OP_SHLR: begin r = {1'b0, x[LW-1:1]};   c = x[0]; end
      OP_SHAR: begin r = {x[LW-1], x[LW-1:1]}; c = x[0]; end
      OP_ROTL: begin r = {x[LW-2:0], x[LW-1]}; c = x[LW-1]; end
      OP_ROTR: begin r = {x[0], x[LW-1:1]};   c = x[0]; end
      OP_ROTXL: begin r = {x[LW-2:0], cin};   c = x[LW-1]; end
      OP_ROTXR: begin r = {cin, x[LW-1:1]};   c = x[0]; end
      default: begin r = x; c = 1'b0; end
    endcase
    return {v, c, r};
  endfunction

  logic [LW+1:0] first_s;
  logic [LW+1:0] second_s;
  logic          is_move;

  assign first_s  = step(op_i, x_i, cin_i);
  // second step uses the first step's carry as its incoming carry
  assign second_s = step(op_i, first_s[LW-1:0], first_s[LW]);
  assign is_move  = (op_i <= OP_ROTXR);

  always_comb begin
    if (op_i == OP_NOT) begin
      r_o = ~x_i;
      c_o = 1'b0;
      v_o = 1'b0;
    end else if (is_move && two_i) begin
      r_o = second_s[LW-1:0];
      c_o = second_s[LW];
      v_o = first_s[LW+1] | second_s[LW+1];
    end else if (is_move) begin
      r_o = first_s[LW-1:0];
      c_o = first_s[LW];
      v_o = first_s[LW+1];
    end else begin
      r_o = x_i;
      c_o = 1'b0;
      v_o = 1'b0;
    end
  end

endmodule

// File: rtl/shru_flags.sv
// Derives N and Z from the result at the selected width.
module shru_flags #(
  parameter int BYTE_W    = 8,
  parameter int NUM_SIZES = 3,
  localparam int MAX_W    = BYTE_W << (NUM_SIZES - 1),
  localparam int SZ_W     = $clog2(NUM_SIZES)
) (
  input  logic [MAX_W-1:0] res_i,
  input  logic [SZ_W-1:0]  sel_i,
  output logic             n_o,
  output logic             z_o
);

  logic [NUM_SIZES-1:0] lane_msb;
  logic [NUM_SIZES-1:0] lane_zero;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_flag
    localparam int LW = BYTE_W << g;
    assign lane_msb[g]  = res_i[LW-1];
    assign lane_zero[g] = (res_i[LW-1:0] == '0);
  end

  assign n_o = lane_msb[sel_i];
  assign z_o = lane_zero[sel_i];

endmodule

// File: rtl/shift_rotate_unit.sv
// Combinational shift / rotate / complement datapath with flag outputs.
module shift_rotate_unit
  import shru_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_SIZES = 3,
  localparam int MAX_W    = BYTE_W << (NUM_SIZES - 1),
  localparam int SZ_W     = $clog2(NUM_SIZES)
) (
  input  logic [MAX_W-1:0] opnd_i,
  input  logic [SZ_W-1:0]  size_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic             two_i,
  input  logic             carry_i,
  output logic [MAX_W-1:0] result_o,
  output logic             n_o,
  output logic             z_o,
  output logic             v_o,
  output logic             c_o
);

  shru_op_e             op_s;
  logic [SZ_W-1:0]      sel_idx;
  logic [MAX_W-1:0]     lane_res [NUM_SIZES];
  logic [NUM_SIZES-1:0] lane_c;
  logic [NUM_SIZES-1:0] lane_v;

  assign op_s = shru_op_e'(op_i);

  // codes beyond the last size fall back to the widest lane
  assign sel_idx = (size_i >= SZ_W'(NUM_SIZES)) ? SZ_W'(NUM_SIZES - 1) : size_i;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
    localparam int LW = BYTE_W << g;
    logic [LW-1:0] r_s;
    shru_lane #(.LW(LW)) lane_i (
      .x_i   (opnd_i[LW-1:0]),
      .op_i  (op_s),
      .two_i (two_i),
      .cin_i (carry_i),
      .r_o   (r_s),
      .c_o   (lane_c[g]),
      .v_o   (lane_v[g])
    );
    assign lane_res[g] = MAX_W'(r_s);
  end

  assign result_o = lane_res[sel_idx];
  assign c_o      = lane_c[sel_idx];
  assign v_o      = lane_v[sel_idx];

  shru_flags #(.BYTE_W(BYTE_W), .NUM_SIZES(NUM_SIZES)) flags_i (
    .res_i (result_o),
    .sel_i (sel_idx),
    .n_o   (n_o),
    .z_o   (z_o)
  );

endmodule

// File: rtl/shru_checker.sv
// Property checker attached to the unit; immediate checks on settled values.
module shru_checker
  import shru_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_SIZES = 3,
  localparam int MAX_W    = BYTE_W << (NUM_SIZES - 1),
  localparam int SZ_W     = $clog2(NUM_SIZES)
) (
  input logic [MAX_W-1:0] opnd_i,
  input logic [OP_W-1:0]  op_i,
  input logic [SZ_W-1:0]  sel_idx,
  input logic [MAX_W-1:0] result_o,
  input logic             n_o,
  input logic             z_o,
  input logic             v_o,
  input logic             c_o
);

  logic [MAX_W-1:0] mask;
  logic [MAX_W-1:0] top_bit;
  logic             res_msb;
  logic             opnd_msb;

  assign mask     = {MAX_W{1'b1}} >> (MAX_W - (BYTE_W << sel_idx));
  assign top_bit  = mask ^ (mask >> 1);
  assign res_msb  = |(result_o & top_bit);
  assign opnd_msb = |(opnd_i & top_bit);

  always_comb begin
    if (!$isunknown({opnd_i, op_i, sel_idx, result_o, n_o, z_o, v_o, c_o})) begin
      assert_upper_zero_R1: assert ((result_o & ~mask) == '0);
      assert_zero_flag_R9: assert (z_o == ((result_o & mask) == '0));
      assert_neg_flag_R9: assert (n_o == res_msb);
      if (op_i == OP_SHLR) begin
        assert_lsr_fill_R4: assert (!res_msb && !v_o);
      end
      if (op_i == OP_SHAR) begin
        assert_asr_sign_R5: assert (res_msb == opnd_msb && !v_o);
      end
      if (op_i == OP_NOT) begin
        assert_not_invert_R10: assert ((((result_o ^ opnd_i) & mask) == mask) && !v_o && !c_o);
      end
      if (op_i > OP_NOT) begin
        assert_reserved_pass_R12: assert ((result_o == (opnd_i & mask)) && !v_o && !c_o);
      end
    end
  end

endmodule

bind shift_rotate_unit shru_checker #(.BYTE_W(BYTE_W), .NUM_SIZES(NUM_SIZES)) chk_i (
  .opnd_i   (opnd_i),
  .op_i     (op_i),
  .sel_idx  (sel_idx),
  .result_o (result_o),
  .n_o      (n_o),
  .z_o      (z_o),
  .v_o      (v_o),
  .c_o      (c_o)
);

// File: tb/shift_rotate_unit_tb_top.sv
module shift_rotate_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opnd;
  logic [1:0]  size;
  logic [3:0]  op;
  logic        two;
  logic        cin;
  logic [31:0] result;
  logic        n_f, z_f, v_f, c_f;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  shift_rotate_unit dut_i (
    .opnd_i(opnd), .size_i(size), .op_i(op), .two_i(two), .carry_i(cin),
    .result_o(result), .n_o(n_f), .z_o(z_f), .v_o(v_f), .c_o(c_f)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish (actual timeout, expected completion)");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // Independent model: returns {n, z, v, c, result[31:0]}
  function automatic logic [35:0] model(input int o, input int s, input bit tw,
                                        input bit ci, input logic [31:0] xin);
    int w;
    int k;
    logic [63:0] m, a, r, t, t2, m1;
    bit c, v, sg;
    w  = (s == 0) ? 8 : (s == 1) ? 16 : 32;
    k  = tw ? 2 : 1;
    m  = (64'd1 << w) - 64'd1;
    m1 = (64'd1 << (w + 1)) - 64'd1;
    a  = {32'd0, xin} & m;
    sg = a[w-1];
    c = 1'b0; v = 1'b0;
    case (o)
      0, 2: begin
        r = (a << k) & m; c = a[w-k];
        if (o == 2) for (int i = 1; i <= k; i++) if (a[w-1-i] != sg) v = 1'b1;
      end
      1: begin r = a >> k; c = a[k-1]; end
      3: begin r = (a >> k) | (sg ? (m & ~(m >> k)) : 64'd0); c = a[k-1]; end
      4: begin r = ((a << k) | (a >> (w - k))) & m; c = r[0]; end
      5: begin r = ((a >> k) | (a << (w - k))) & m; c = r[w-1]; end
      6: begin
        t = ({63'd0, ci} << w) | a;
        t2 = ((t << k) | (t >> (w + 1 - k))) & m1;
        r = t2 & m; c = t2[w];
      end
      7: begin
        t = ({63'd0, ci} << w) | a;
        t2 = ((t >> k) | (t << (w + 1 - k))) & m1;
        r = t2 & m; c = t2[w];
      end
      8: r = ~a & m;
      default: r = a;
    endcase
    return {r[w-1], (r == 64'd0), v, c, r[31:0]};
  endfunction

  task automatic apply(input int o, input int s, input bit tw, input bit ci,
                       input logic [31:0] xin);
    @(negedge clk);
    op = 4'(o); size = 2'(s); two = tw; cin = ci; opnd = xin;
    #5;
  endtask

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual nzvc=%b res=%h, expected nzvc=%b res=%h",
               req, act[35:32], act[31:0], exp[35:32], exp[31:0]);
    end
  endtask

  function automatic logic [35:0] got();
    return {n_f, z_f, v_f, c_f, result};
  endfunction

  // directed vector with hand-computed expectation (flags n,z,v,c)
  task automatic vec(input string req, input int o, input int s, input bit tw, input bit ci,
                     input logic [31:0] xin, input logic [31:0] er, input logic [3:0] ef);
    apply(o, s, tw, ci, xin);
    check(req, got(), {ef, er});
  endtask

  task automatic t_reset();
    vec("R9 idle state", 0, 0, 0, 0, 32'h0, 32'h0, 4'b0100);
  endtask

  task automatic t_left_shift();
    vec("R3 shll 32 by 2",   0, 2, 1, 0, 32'h4000_0001, 32'h0000_0004, 4'b0001);
    vec("R3 shll 8 by 1",    0, 0, 0, 0, 32'h0000_0081, 32'h0000_0002, 4'b0001);
    vec("R2 shll by 1 vs 2", 0, 0, 1, 0, 32'h0000_0081, 32'h0000_0004, 4'b0000);
  endtask

  task automatic t_arith_left();
    vec("R6 shal 8 sign flips",      2, 0, 0, 0, 32'h40, 32'h80, 4'b1010);
    vec("R6 shal 8 by 2 new sign",   2, 0, 1, 0, 32'h20, 32'h80, 4'b1010);
    vec("R6 shal 8 no overflow",     2, 0, 0, 0, 32'hC0, 32'h80, 4'b1001);
    vec("R6 shal 16 third bit only", 2, 1, 1, 0, 32'hC000, 32'h0000, 4'b0111);
  endtask

  task automatic t_right_shift();
    vec("R4 shlr 32 by 2 to zero", 1, 2, 1, 0, 32'h3, 32'h0, 4'b0101);
    vec("R1 shlr 8 upper ignored", 1, 0, 0, 0, 32'hFFFF_FF80, 32'h40, 4'b0000);
    vec("R1 size 3 is 32 bit",     1, 3, 0, 0, 32'h8000_0000, 32'h4000_0000, 4'b0000);
    vec("R5 shar 16 by 1",         3, 1, 0, 0, 32'h8001, 32'hC000, 4'b1001);
    vec("R5 shar 16 by 2",         3, 1, 1, 0, 32'h8001, 32'hE000, 4'b1000);
    vec("R5 shar 8 positive",      3, 0, 1, 0, 32'h7F, 32'h1F, 4'b0001);
  endtask

  task automatic t_rotate();
    vec("R7 rotl 16 by 2", 4, 1, 1, 0, 32'h8001, 32'h0006, 4'b0000);
    vec("R7 rotl 8 by 1",  4, 0, 0, 0, 32'h80, 32'h01, 4'b0001);
    vec("R7 rotr 8 by 1",  5, 0, 0, 0, 32'h01, 32'h80, 4'b1001);
    vec("R7 rotr 32 by 2", 5, 2, 1, 0, 32'h2, 32'h8000_0000, 4'b1001);
  endtask

  task automatic t_rotate_carry();
    logic [35:0] one_a, one_b, both;
    vec("R8 rotxl 8 by 2",  6, 0, 1, 0, 32'h80, 32'h01, 4'b0000);
    vec("R8 rotxl 8 by 1",  6, 0, 0, 1, 32'h80, 32'h01, 4'b0001);
    vec("R8 rotxr 8 by 2",  7, 0, 1, 1, 32'h01, 32'hC0, 4'b1000);
    vec("R8 rotxr 16 by 1", 7, 1, 0, 1, 32'h0, 32'h8000, 4'b1000);
    // two single steps with carry fed back must equal one double step
    for (int o = 6; o <= 7; o++) begin
      for (int ci = 0; ci < 2; ci++) begin
        apply(o, 1, 0, ci[0], 32'h4002);
        one_a = got();
        apply(o, 1, 0, one_a[32], one_a[31:0]);
        one_b = got();
        apply(o, 1, 1, ci[0], 32'h4002);
        both = got();
        check("R8 R2 double equals two singles", both, one_b);
      end
    end
  endtask

  task automatic t_complement();
    vec("R10 not 8",        8, 0, 0, 1, 32'hFFFF_FF5A, 32'hA5, 4'b1000);
    vec("R10 not 32 zero",  8, 2, 1, 1, 32'hFFFF_FFFF, 32'h0, 4'b0100);
  endtask

  task automatic t_reserved();
    vec("R12 reserved pass", 9, 1, 1, 1, 32'h1234_8765, 32'h8765, 4'b1000);
    vec("R12 reserved 15",   15, 0, 0, 0, 32'h1234_5600, 32'h00, 4'b0100);
  endtask

  task automatic t_ignore_carry();
    logic [35:0] r0;
    for (int o = 0; o < 16; o++) begin
      if (o == 6 || o == 7) continue;
      apply(o, o % 3, o[0], 1'b0, 32'hA5C3_8181);
      r0 = got();
      apply(o, o % 3, o[0], 1'b1, 32'hA5C3_8181);
      check("R11 carry in ignored", got(), r0);
    end
  endtask

  task automatic t_sweep();
    logic [31:0] lfsr;
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 800; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      apply(int'(lfsr[3:0]), int'(lfsr[5:4]), lfsr[6], lfsr[7], lfsr ^ {lfsr[15:0], lfsr[31:16]});
      check("R1 R3 R4 R5 R6 R7 R8 R9 sweep", got(),
            model(int'(lfsr[3:0]), int'(lfsr[5:4]), lfsr[6], lfsr[7],
                  lfsr ^ {lfsr[15:0], lfsr[31:16]}));
    end
  endtask

  initial begin
    opnd = '0; size = '0; op = '0; two = 1'b0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_left_shift();
    t_arith_left();
    t_right_shift();
    t_rotate();
    t_rotate_carry();
    t_complement();
    t_reserved();
    t_ignore_carry();
    t_sweep();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule